// File: doc/BRIEF.md
# Oversampling Serial Receiver with Wakeup Standby

This block receives asynchronous serial frames on a single input line. Each frame has one start bit, eight or nine data bits sent least significant bit first, and one stop bit. The line is sampled at sixteen times the bit rate, and a divider derives that sample rate from the system clock. A received frame is kept in a data register and raises a receive-full flag. A second flag reports that the line has been quiet for one frame time after the last accepted frame. Both flags drive a CPU interrupt output, or a DMA request output when DMA service is selected.

Software can place the receiver in a standby state. While in standby the receiver raises no interrupt or DMA request, and it does not load ordinary frames. One of two wakeup methods ends standby, and the standby bit then clears in hardware:
- **Idle-line wakeup:** the line stays high for a full frame time.
- **Address-mark wakeup:** a frame arrives whose top data bit is set. That frame is kept as received data.

All controls are written together through a single write strobe. Reading the data is acknowledged with a pulse, and so is reading the idle flag.

Top module: `uart_standby_rx`

## Requirements
- R1: An 8-bit frame with a high stop bit loads its data, least significant bit first, into `rx_data[7:0]` with `rx_data[8]`=0, and sets `rx_full`. A `data_ack` pulse clears `rx_full`.
- R2: With `ctl_nine`=1 the frame carries nine data bits, and the ninth received bit appears on `rx_data[8]`.
- R3: A start bit counts only if the majority of sample positions 7, 8 and 9 (out of 0 to 15, counted from the first low sample) is low. A low pulse shorter than that starts no frame. A frame whose stop bit votes low is discarded, and `rx_full` is left unchanged.
- R4: Reset clears the standby bit, the receiver enable and every other control, and it clears `rx_full`, `idle_flag`, `irq` and `dma_req`.
- R5: A write to the receiver enable takes effect only if the global enable was already set before that write. Otherwise the write leaves the receiver enable unchanged.
- R6: Clearing the receiver enable (while the global enable is set) stops reception and leaves `rx_full`, `idle_flag` and `rx_data` unchanged.
- R7: While `standby` is 1, `irq` and `dma_req` stay 0, even with a flag set.
- R8: With address-mark wakeup selected (`ctl_wake_addr`=1), a frame received in standby whose top data bit is 0 is discarded. A frame whose top data bit is 1 (bit 7 in 8-bit mode, bit 8 in 9-bit mode) clears `standby` and is loaded with `rx_full` set.
- R9: With idle-line wakeup selected (`ctl_wake_addr`=0), frames received in standby are discarded. `standby` clears once the line has been high for one frame time (10 bit times in 8-bit mode, 11 in 9-bit mode) after the standby write or after the last frame activity.
- R10: `idle_flag` sets when the line stays high for one frame time after an accepted frame, outside standby. `idle_ack` clears it. `irq` is `rx_full`, OR'd with `idle_flag` when `ctl_idle_ie` is set.
- R11: With `ctl_dma_on`=1, `irq` stays 0 whatever `ctl_idle_ie` is, and `dma_req` equals `rx_full` outside standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rxd | input | 1 | Serial receive line, idle high |
| ctl_we | input | 1 | Write strobe; loads all control fields below |
| ctl_unit_on | input | 1 | Global enable |
| ctl_rx_on | input | 1 | Receiver enable (gated by the global enable already in force) |
| ctl_standby | input | 1 | Enter standby when 1 |
| ctl_wake_addr | input | 1 | Wakeup method: 1 address mark, 0 idle line |
| ctl_idle_ie | input | 1 | Idle-line interrupt enable |
| ctl_dma_on | input | 1 | Route receive-full to DMA request and mask CPU interrupts |
| ctl_nine | input | 1 | 1 selects nine data bits per frame |
| data_ack | input | 1 | Pulse: received data taken, clears rx_full |
| idle_ack | input | 1 | Pulse: clears idle_flag |
| rx_data | output | 9 | Last accepted frame data |
| rx_full | output | 1 | Received data waiting |
| idle_flag | output | 1 | Line idle after accepted frame |
| standby | output | 1 | Standby bit |
| irq | output | 1 | CPU receive interrupt request |
| dma_req | output | 1 | DMA service request |

## Verification
The inline assertions check these rules on every cycle:
- the receiver enable stays unchanged when written with the global enable off;
- the receive-full flag holds while the receiver is stopped and no acknowledge arrives;
- both request outputs stay quiet in standby;
- an address-mark frame always ends standby;
- DMA mode masks the CPU interrupt.

They also check that the bit engine returns to its idle state whenever reception is disabled, and that the idle counter never exceeds the frame length. Only the bench scenarios show the parts that depend on a whole frame:
- the bit order and nine-bit data;
- rejection of short start pulses and of bad stop bits;
- the exact frame-time length of the idle-line wakeup and of the idle flag;
- which frames standby discards.

// File: rtl/uart_sb_pkg.sv
package uart_sb_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart_sb_tick.sv
module uart_sb_tick #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_sb_engine.sv
module uart_sb_engine
  import uart_sb_pkg::*;
#(
  parameter int OSR  = 16,
  parameter int DMAX = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            tick,
  input  logic            rxd,
  input  logic            nine,
  output logic            frame_done,
  output logic [DMAX-1:0] frame_data,
  output logic            busy
);
  localparam int SW  = $clog2(OSR);
  localparam int BW  = $clog2(DMAX + 1);
  localparam logic [SW-1:0] S_A  = SW'(OSR / 2 - 1);
  localparam logic [SW-1:0] S_B  = SW'(OSR / 2);
  localparam logic [SW-1:0] S_C  = SW'(OSR / 2 + 1);
  localparam logic [SW-1:0] S_LAST = SW'(OSR - 1);

  rx_state_e       state_q, state_d;
  logic [SW-1:0]   cnt_q, cnt_d;
  logic [BW-1:0]   bit_q, bit_d;
  logic [DMAX-1:0] shf_q, shf_d;
  logic            sa_q, sa_d, sb_q, sb_d;
  logic            vote;
  logic [BW-1:0]   nbits;

  assign vote  = (sa_q & sb_q) | (sa_q & rxd) | (sb_q & rxd);
  assign nbits = nine ? BW'(DMAX) : BW'(DMAX - 1);
  assign busy  = (state_q != RX_IDLE);
  assign frame_data = nine ? shf_q : (shf_q >> 1);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    bit_d      = bit_q;
    shf_d      = shf_q;
    sa_d       = sa_q;
    sb_d       = sb_q;
    frame_done = 1'b0;
    if (!en) begin
      state_d = RX_IDLE;
      cnt_d   = '0;
    end else if (tick) begin
      if (state_q == RX_IDLE) begin
        if (!rxd) begin
          state_d = RX_START;
          cnt_d   = SW'(1);
        end
      end else begin
        cnt_d = (cnt_q == S_LAST) ? '0 : cnt_q + SW'(1);
        if (cnt_q == S_A) sa_d = rxd;
        if (cnt_q == S_B) sb_d = rxd;
        if (cnt_q == S_C) begin
          unique case (state_q)
            RX_START: if (vote) begin
              state_d = RX_IDLE;
              cnt_d   = '0;
            end
            RX_DATA: begin
              shf_d = {vote, shf_q[DMAX-1:1]};
              bit_d = bit_q + BW'(1);
            end
            RX_STOP: begin
              state_d    = RX_IDLE;
              cnt_d      = '0;
              frame_done = vote;
            end
            default: ;
          endcase
        end
        if (cnt_q == S_LAST) begin
          if (state_q == RX_START) begin
            state_d = RX_DATA;
            bit_d   = '0;
          end else if (state_q == RX_DATA && bit_q == nbits) begin
            state_d = RX_STOP;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shf_q   <= '0;
      sa_q    <= 1'b1;
      sb_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shf_q   <= shf_d;
      sa_q    <= sa_d;
      sb_q    <= sb_d;
    end
  end

  // R6: a disabled receiver always falls back to its idle state
  assert_idle_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> state_q == RX_IDLE);
endmodule

// File: rtl/uart_sb_idle.sv
module uart_sb_idle #(
  parameter int OSR  = 16,
  parameter int DMAX = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic rxd,
  input  logic busy,
  input  logic clr,
  input  logic nine,
  output logic idle_hit
);
  localparam int LIM9 = (DMAX + 2) * OSR;
  localparam int LIM8 = (DMAX + 1) * OSR;
  localparam int CW   = $clog2(LIM9 + 1);

  logic [CW-1:0] cnt_q, cnt_d, limit;
  logic          quiet;

  assign limit    = nine ? CW'(LIM9) : CW'(LIM8);
  assign quiet    = en && !busy && rxd && !clr;
  assign idle_hit = quiet && tick && (cnt_q == limit - CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!quiet)                      cnt_d = '0;
    else if (tick && cnt_q < limit)  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: the quiet-time counter stops at one frame time
  assert_cnt_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIM9));
endmodule

// File: rtl/uart_standby_rx.sv
module uart_standby_rx #(
  parameter int CLK_DIV = 4,
  parameter int OSR     = 16,
  parameter int DMAX    = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rxd,
  input  logic            ctl_we,
  input  logic            ctl_unit_on,
  input  logic            ctl_rx_on,
  input  logic            ctl_standby,
  input  logic            ctl_wake_addr,
  input  logic            ctl_idle_ie,
  input  logic            ctl_dma_on,
  input  logic            ctl_nine,
  input  logic            data_ack,
  input  logic            idle_ack,
  output logic [DMAX-1:0] rx_data,
  output logic            rx_full,
  output logic            idle_flag,
  output logic            standby,
  output logic            irq,
  output logic            dma_req
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  // input synchroniser
  logic rxd_m_q, rxd_s_q;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rxd_m_q <= 1'b1;
      rxd_s_q <= 1'b1;
    end else begin
      rxd_m_q <= rxd;
      rxd_s_q <= rxd_m_q;
    end
  end

  // control state
  logic unit_on_q, rx_on_q, standby_q, wake_addr_q, idle_ie_q, dma_on_q, nine_q;
  logic rx_on_d, standby_d;
  logic rx_full_q, rx_full_d, idle_q, idle_d, armed_q, armed_d;
  logic [DMAX-1:0] data_q, data_d;

  logic rx_active, tick, frame_done, busy, idle_hit, top_bit;
  logic addr_wake, idle_wake, load;
  logic [DMAX-1:0] frame_data;

  assign rx_active = unit_on_q & rx_on_q;

  uart_sb_tick #(.CLK_DIV(CLK_DIV)) i_tick (
    .clk (clk), .rst_n (rst_q), .en (rx_active), .tick (tick)
  );

  uart_sb_engine #(.OSR(OSR), .DMAX(DMAX)) i_engine (
    .clk (clk), .rst_n (rst_q), .en (rx_active), .tick (tick),
    .rxd (rxd_s_q), .nine (nine_q), .frame_done (frame_done),
    .frame_data (frame_data), .busy (busy)
  );

  uart_sb_idle #(.OSR(OSR), .DMAX(DMAX)) i_idle (
    .clk (clk), .rst_n (rst_q), .en (rx_active), .tick (tick),
    .rxd (rxd_s_q), .busy (busy), .clr (ctl_we & ctl_standby),
    .nine (nine_q), .idle_hit (idle_hit)
  );

  assign top_bit   = nine_q ? frame_data[DMAX-1] : frame_data[DMAX-2];
  assign addr_wake = standby_q & wake_addr_q & frame_done & top_bit;
  assign idle_wake = standby_q & ~wake_addr_q & idle_hit;
  assign load      = frame_done & (~standby_q | addr_wake);

  always_comb begin
    rx_on_d   = rx_on_q;
    standby_d = standby_q;
    if (ctl_we) begin
      if (unit_on_q) rx_on_d = ctl_rx_on;
      standby_d = ctl_standby;
    end else if (addr_wake || idle_wake) begin
      standby_d = 1'b0;
    end

    rx_full_d = rx_full_q;
    data_d    = data_q;
    if (load) begin
      rx_full_d = 1'b1;
      data_d    = frame_data;
    end else if (data_ack) begin
      rx_full_d = 1'b0;
    end

    armed_d = armed_q;
    idle_d  = idle_q;
    if (idle_hit && !standby_q && armed_q) begin
      idle_d  = 1'b1;
      armed_d = 1'b0;
    end else if (idle_ack) begin
      idle_d = 1'b0;
    end
    if (load) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      unit_on_q   <= 1'b0;
      rx_on_q     <= 1'b0;
      standby_q   <= 1'b0;
      wake_addr_q <= 1'b0;
      idle_ie_q   <= 1'b0;
      dma_on_q    <= 1'b0;
      nine_q      <= 1'b0;
      rx_full_q   <= 1'b0;
      idle_q      <= 1'b0;
      armed_q     <= 1'b0;
      data_q      <= '0;
    end else begin
      if (ctl_we) begin
        unit_on_q   <= ctl_unit_on;
        wake_addr_q <= ctl_wake_addr;
        idle_ie_q   <= ctl_idle_ie;
        dma_on_q    <= ctl_dma_on;
        nine_q      <= ctl_nine;
      end
      rx_on_q   <= rx_on_d;
      standby_q <= standby_d;
      rx_full_q <= rx_full_d;
      idle_q    <= idle_d;
      armed_q   <= armed_d;
      data_q    <= data_d;
    end
  end

  assign rx_data   = data_q;
  assign rx_full   = rx_full_q;
  assign idle_flag = idle_q;
  assign standby   = standby_q;
  assign irq       = ~standby_q & ~dma_on_q & (rx_full_q | (idle_q & idle_ie_q));
  assign dma_req   = ~standby_q & dma_on_q & rx_full_q;

  // R5: receiver enable is locked while the global enable is off
  assert_rx_lock_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (ctl_we && !unit_on_q) |=> $stable(rx_on_q));
  // R6: a stopped receiver keeps its receive-full flag
  assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (!rx_active && !data_ack) |=> $stable(rx_full_q));
  // R7: no request of either kind leaves the block in standby
  assert_standby_quiet_R7: assert property (@(posedge clk) disable iff (!rst_q)
    standby_q |-> (!irq && !dma_req));
  // R8: an address-marked frame ends standby and loads data
  assert_addr_wake_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (addr_wake && !ctl_we) |=> (!standby_q && rx_full_q));
  // R11: DMA mode masks the CPU interrupt
  assert_dma_mask_R11: assert property (@(posedge clk) disable iff (!rst_q)
    dma_on_q |-> !irq);
endmodule

// File: tb/test_uart_standby_rx.sv
module test_uart_standby_rx;
  localparam int BITCLK = 64; // CLK_DIV 4 x OSR 16

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic ctl_we = 1'b0, ctl_unit_on = 1'b0, ctl_rx_on = 1'b0, ctl_standby = 1'b0;
  logic ctl_wake_addr = 1'b0, ctl_idle_ie = 1'b0, ctl_dma_on = 1'b0, ctl_nine = 1'b0;
  logic data_ack = 1'b0, idle_ack = 1'b0;
  logic [8:0] rx_data;
  logic rx_full, idle_flag, standby, irq, dma_req;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  uart_standby_rx i_uart_standby_rx (
    .clk (clk), .rst_n (rst_n), .rxd (rxd),
    .ctl_we (ctl_we), .ctl_unit_on (ctl_unit_on), .ctl_rx_on (ctl_rx_on),
    .ctl_standby (ctl_standby), .ctl_wake_addr (ctl_wake_addr),
    .ctl_idle_ie (ctl_idle_ie), .ctl_dma_on (ctl_dma_on), .ctl_nine (ctl_nine),
    .data_ack (data_ack), .idle_ack (idle_ack),
    .rx_data (rx_data), .rx_full (rx_full), .idle_flag (idle_flag),
    .standby (standby), .irq (irq), .dma_req (dma_req)
  );

  // {nine, stop bit level, 9-bit payload}
  localparam logic [10:0] VEC [0:5] = '{
    {1'b0, 1'b1, 9'h0A5}, {1'b0, 1'b1, 9'h13C}, {1'b1, 1'b1, 9'h1A5},
    {1'b1, 1'b1, 9'h0FF}, {1'b0, 1'b0, 9'h055}, {1'b1, 1'b1, 9'h100}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic u, input logic r, input logic s, input logic wa,
                        input logic ie, input logic d, input logic n);
    @(negedge clk);
    ctl_unit_on = u; ctl_rx_on = r; ctl_standby = s; ctl_wake_addr = wa;
    ctl_idle_ie = ie; ctl_dma_on = d; ctl_nine = n; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic ack_data();
    @(negedge clk); data_ack = 1'b1;
    @(negedge clk); data_ack = 1'b0;
  endtask

  task automatic ack_idle();
    @(negedge clk); idle_ack = 1'b1;
    @(negedge clk); idle_ack = 1'b0;
  endtask

  task automatic send(input logic [8:0] d, input bit nine, input logic stopv);
    @(negedge clk);
    rxd = 1'b0; clks(BITCLK);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rxd = d[i]; clks(BITCLK);
    end
    rxd = stopv; clks(BITCLK);
    rxd = 1'b1; clks(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] exp_d;
    clks(3); rst_n = 1'b1; clks(4);

    // R4: reset state
    chk(rx_full == 0 && idle_flag == 0, "R4 flags after reset", {rx_full, idle_flag}, 0);
    chk(standby == 0 && irq == 0 && dma_req == 0, "R4 outputs after reset",
        {standby, irq, dma_req}, 0);

    // R5: receiver enable ignored while global enable was off
    wr_ctl(0, 1, 0, 0, 0, 0, 0);
    wr_ctl(1, 1, 0, 0, 0, 0, 0);
    send(9'h5A, 0, 1'b1);
    chk(rx_full == 0, "R5 enable write ignored", rx_full, 0);
    wr_ctl(1, 1, 0, 0, 0, 0, 0);
    send(9'h5A, 0, 1'b1);
    chk(rx_full == 1 && rx_data == 9'h05A, "R5 enable after global on", rx_data, 9'h05A);
    ack_data();

    // R1 R2 R3: vector table
    for (int v = 0; v < 6; v++) begin
      wr_ctl(1, 1, 0, 0, 0, 0, VEC[v][10]);
      send(VEC[v][8:0], VEC[v][10], VEC[v][9]);
      exp_d = VEC[v][10] ? VEC[v][8:0] : {1'b0, VEC[v][7:0]};
      if (VEC[v][9]) begin
        chk(rx_full == 1 && rx_data == exp_d,
            VEC[v][10] ? "R2 nine-bit frame" : "R1 eight-bit frame", rx_data, exp_d);
        ack_data();
        chk(rx_full == 0, "R1 data_ack clears full", rx_full, 0);
      end else begin
        chk(rx_full == 0, "R3 bad stop discarded", rx_full, 0);
      end
    end

    // R3: short low glitch starts no frame
    wr_ctl(1, 1, 0, 0, 0, 0, 0);
    @(negedge clk); rxd = 1'b0; clks(16); rxd = 1'b1;
    clks(12 * BITCLK);
    chk(rx_full == 0, "R3 glitch rejected", rx_full, 0);

    // R10: idle flag and interrupt
    ack_idle();
    wr_ctl(1, 1, 0, 0, 1, 0, 0);
    send(9'h3C, 0, 1'b1);
    chk(irq == 1, "R10 irq on full", irq, 1);
    ack_data();
    chk(irq == 0 && idle_flag == 0, "R10 before idle time", {irq, idle_flag}, 0);
    clks(800);
    chk(idle_flag == 1 && irq == 1, "R10 idle flag irq", {idle_flag, irq}, 3);
    ack_idle();
    chk(idle_flag == 0 && irq == 0, "R10 idle_ack", {idle_flag, irq}, 0);

    // R11: DMA mode
    wr_ctl(1, 1, 0, 0, 1, 1, 0);
    send(9'h81, 0, 1'b1);
    chk(dma_req == 1 && irq == 0, "R11 dma request", {dma_req, irq}, 2);
    clks(800);
    chk(idle_flag == 1 && irq == 0, "R11 idle_ie no effect", {idle_flag, irq}, 2);
    ack_data(); ack_idle();
    chk(dma_req == 0, "R11 dma follows full", dma_req, 0);

    // R7 R8: address-mark wakeup
    wr_ctl(1, 1, 0, 1, 0, 0, 0);
    send(9'h21, 0, 1'b1);
    chk(irq == 1, "R7 irq before standby", irq, 1);
    wr_ctl(1, 1, 1, 1, 0, 0, 0);
    chk(standby == 1 && irq == 0, "R7 standby masks irq", {standby, irq}, 2);
    send(9'h12, 0, 1'b1);
    chk(standby == 1 && rx_data == 9'h021, "R8 plain frame discarded", rx_data, 9'h021);
    send(9'h85, 0, 1'b1);
    chk(standby == 0 && rx_data == 9'h085 && rx_full == 1, "R8 address wake",
        {standby, rx_data}, 9'h085);
    ack_data();

    // R9: idle-line wakeup
    wr_ctl(1, 1, 1, 0, 0, 0, 0);
    send(9'h33, 0, 1'b1);
    chk(rx_full == 0 && standby == 1, "R9 frame in standby dropped", {rx_full, standby}, 1);
    clks(500);
    chk(standby == 1, "R9 not yet a frame time", standby, 1);
    clks(300);
    chk(standby == 0, "R9 idle wake", standby, 0);
    send(9'h44, 0, 1'b1);
    chk(rx_full == 1 && rx_data == 9'h044, "R9 receives after wake", rx_data, 9'h044);

    // R6: disabling keeps flags
    wr_ctl(1, 0, 0, 0, 0, 0, 0);
    chk(rx_full == 1 && rx_data == 9'h044, "R6 flags kept", rx_data, 9'h044);
    send(9'h77, 0, 1'b1);
    chk(rx_full == 1 && rx_data == 9'h044, "R6 no reception", rx_data, 9'h044);

    // R4: reset clears standby and receiver enable
    ack_data();
    wr_ctl(1, 1, 1, 1, 0, 0, 0);
    @(negedge clk); rst_n = 1'b0; clks(3); rst_n = 1'b1; clks(4);
    chk(standby == 0 && rx_full == 0, "R4 reset clears standby", {standby, rx_full}, 0);
    wr_ctl(1, 0, 0, 0, 0, 0, 0);
    send(9'h66, 0, 1'b1);
    chk(rx_full == 0, "R4 reset clears rx enable", rx_full, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule